// File: doc/BRIEF.md
# Coherence Message Network Interface

This block joins a cache or directory controller to one router port. On the send side it takes one coherence message at a time and cuts it into 128-bit flits. Control traffic such as requests, forwards, acknowledgements and unblocks leaves as one flit. A response that carries a 64-byte cache line leaves as a header flit and then four flits of line data. Each packet is placed on the virtual network that belongs to its message class. A flit is only offered while the router's backpressure bit for that virtual network is low.

On the receive side the block rebuilds whole messages from the flits the router ejects. It pulses a message-valid strobe to the controller once the last flit of a packet has arrived. A parameter lets unblock traffic share the response virtual network, because both classes are known to drain.

Top module: `coh_msg_ni`

## Requirements
- R1: After synchronous reset the send side is ready (`tx_msg_ready`=1), and both `tx_flit_valid` and `rx_msg_valid` are 0.
- R2: A message becomes one flit of kind 3 (head-and-tail) in these cases: its class is not a response (code 1 or 4), or `tx_msg_has_line` is 0. For classes other than 1 and 4, `tx_msg_has_line` has no effect.
- R3: A response (class 1 or 4) with `tx_msg_has_line`=1 becomes five flits in this order: kind 1 (head), kind 0 (body) three times, kind 2 (tail). The four data flits carry line bits [127:0], [255:128], [383:256] and [511:384] in that order.
- R4: The header flit holds, from bit 0 upward: class in [2:0], a carries-line bit in [3], message type in [11:4], destination in [19:12] and line address in [67:20]. All bits above 67 are zero.
- R5: The virtual network equals the class code: 0 DMA request, 1 DMA response, 2 request, 3 forward, 4 response, 5 unblock.
- R6: With `SHARE_RSP_UNBLK`=1, unblock packets use virtual network 4 and no flit appears on network 5.
- R7: No flit is valid while `tx_vnet_stall` is set for its virtual network. A stalled flit keeps its data, kind and network unchanged. Backpressure on other networks does not hold a packet back.
- R8: `tx_msg_ready` falls in the cycle after a message is accepted. It stays low until the packet's last flit has been sent, so the flits of two packets never mix.
- R9: `rx_msg_valid` is a one-cycle pulse. It appears in the cycle after a tail or head-and-tail flit is received, and at no other time.
- R10: A received data message presents its line with the first data flit in bits [127:0], in arrival order. A single-flit message presents a zero line.
- R11: A received message reports the class, carries-line bit, type, destination and address decoded from its header flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_msg_valid | input | 1 | Controller offers a message |
| tx_msg_ready | output | 1 | Block can take a message |
| tx_msg_class | input | 3 | Message class code |
| tx_msg_has_line | input | 1 | Message carries a cache line (responses only) |
| tx_msg_type | input | 8 | Protocol message type |
| tx_msg_dest | input | 8 | Destination node |
| tx_msg_addr | input | 48 | Line address |
| tx_msg_line | input | 512 | Cache line data |
| tx_vnet_stall | input | 6 | Per-virtual-network backpressure from the router |
| tx_flit_valid | output | 1 | Flit offered to the router |
| tx_flit_kind | output | 2 | Flit kind: 0 body, 1 head, 2 tail, 3 head-and-tail |
| tx_flit_vnet | output | 3 | Virtual network of the flit |
| tx_flit_data | output | 128 | Flit payload |
| rx_flit_valid | input | 1 | Router ejects a flit |
| rx_flit_kind | input | 2 | Kind of the ejected flit |
| rx_flit_data | input | 128 | Payload of the ejected flit |
| rx_msg_valid | output | 1 | Rebuilt message is complete |
| rx_msg_class | output | 3 | Received class |
| rx_msg_has_line | output | 1 | Received message carries a line |
| rx_msg_type | output | 8 | Received message type |
| rx_msg_dest | output | 8 | Received destination field |
| rx_msg_addr | output | 48 | Received line address |
| rx_msg_line | output | 512 | Received line data |

## Verification
The hardest case to reach is backpressure that arrives partway through a five-flit packet. The packet's head is already out, and the rest must hold still without mixing with anything else. The stimulus reaches this case in two steps. It starts a line-carrying response, then raises the stall bit of that packet's virtual network a few cycles after the message handshake, while body flits are still pending. Separate runs stall a packet before its head leaves, and stall an unrelated network while a packet flows. A loopback from the flit outputs to the flit inputs lets every sent packet also be checked as a rebuilt message.

// File: rtl/coh_ni_pkg.sv
package coh_ni_pkg;
    localparam int FLIT_W    = 128;
    localparam int LINE_W    = 512;
    localparam int NODE_W    = 8;
    localparam int ADDR_W    = 48;
    localparam int MTYPE_W   = 8;
    localparam int NUM_VNETS = 6;
    localparam int CLS_W     = 3;
    localparam int BEATS     = LINE_W / FLIT_W;
    localparam int VNET_W    = $clog2(NUM_VNETS);

    typedef enum logic [CLS_W-1:0] {
        CLS_DMA_REQ = 3'd0,
        CLS_DMA_RSP = 3'd1,
        CLS_REQ     = 3'd2,
        CLS_FWD     = 3'd3,
        CLS_RSP     = 3'd4,
        CLS_UNBLK   = 3'd5
    } msg_class_e;

    typedef enum logic [1:0] {
        FK_BODY = 2'd0,
        FK_HEAD = 2'd1,
        FK_TAIL = 2'd2,
        FK_SOLO = 2'd3
    } flit_kind_e;

    // Packed MSB first: class ends up in the lowest bits of the flit.
    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [NODE_W-1:0]  dest;
        logic [MTYPE_W-1:0] mtype;
        logic               has_line;
        msg_class_e         cls;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    function automatic logic [FLIT_W-1:0] hdr_pack(hdr_t h);
        return {{(FLIT_W-HDR_W){1'b0}}, h};
    endfunction

    function automatic hdr_t hdr_unpack(logic [HDR_W-1:0] f);
        return hdr_t'(f);
    endfunction

    function automatic logic carries_line(msg_class_e c, logic want);
        return want && (c == CLS_RSP || c == CLS_DMA_RSP);
    endfunction

    function automatic logic [VNET_W-1:0] vnet_of(msg_class_e c, bit share);
        if (share && c == CLS_UNBLK) return VNET_W'(CLS_RSP);
        return VNET_W'(c);
    endfunction
endpackage

// File: rtl/coh_ni_tx.sv
module coh_ni_tx
    import coh_ni_pkg::*;
#(
    parameter bit SHARE_RSP_UNBLK = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  hdr_t                 msg_hdr,
    input  logic [LINE_W-1:0]    msg_line,
    input  logic [NUM_VNETS-1:0] stall,
    output logic                 flit_valid,
    output flit_kind_e           flit_kind,
    output logic [VNET_W-1:0]    flit_vnet,
    output logic [FLIT_W-1:0]    flit_data
);
    localparam int BEAT_W = $clog2(BEATS + 1);

    logic              busy_q;
    logic [BEAT_W-1:0] beat_q;
    logic              long_q;
    hdr_t              hdr_q;
    logic [LINE_W-1:0] line_q;
    logic [VNET_W-1:0] vnet_q;
    logic              last_beat;
    logic              send;
    logic              long_d;

    assign long_d    = carries_line(msg_hdr.cls, msg_hdr.has_line);
    assign msg_ready = !busy_q;

    always_comb begin
        last_beat  = !long_q || (beat_q == BEAT_W'(BEATS));
        send       = busy_q && !stall[vnet_q];
        flit_valid = send;
        flit_vnet  = vnet_q;
        if (beat_q == '0) begin
            flit_data = hdr_pack(hdr_q);
            flit_kind = long_q ? FK_HEAD : FK_SOLO;
        end else begin
            flit_data = line_q[FLIT_W-1:0];
            flit_kind = last_beat ? FK_TAIL : FK_BODY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            long_q <= 1'b0;
            hdr_q  <= '0;
            line_q <= '0;
            vnet_q <= '0;
        end else if (!busy_q) begin
            if (msg_valid) begin
                busy_q         <= 1'b1;
                beat_q         <= '0;
                long_q         <= long_d;
                hdr_q          <= msg_hdr;
                hdr_q.has_line <= long_d;
                line_q         <= msg_line;
                vnet_q         <= vnet_of(msg_hdr.cls, SHARE_RSP_UNBLK);
            end
        end else if (send) begin
            if (last_beat) busy_q <= 1'b0;
            else           beat_q <= beat_q + 1'b1;
            if (beat_q != '0) line_q <= line_q >> FLIT_W;
        end
    end

    // R8: one message at a time
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_ready);

    // R7: a held flit does not change
    p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
        (!msg_ready && !flit_valid) |=>
            ($stable(flit_data) && $stable(flit_kind) && $stable(flit_vnet)));

    // R6: shared mode keeps network 5 empty
    p_no_vnet5_shared_r6: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && SHARE_RSP_UNBLK) |-> (flit_vnet != VNET_W'(CLS_UNBLK)));

    // R8: ready stays low while a packet is unfinished
    p_no_ready_midpkt_r8: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && (flit_kind == FK_HEAD || flit_kind == FK_BODY)) |=> !msg_ready);
endmodule

// File: rtl/coh_ni_rx.sv
module coh_ni_rx
    import coh_ni_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flit_valid,
    input  logic [1:0]        flit_kind,
    input  logic [FLIT_W-1:0] flit_data,
    output logic              msg_valid,
    output hdr_t              msg_hdr,
    output logic [LINE_W-1:0] msg_line
);
    hdr_t              hdr_q;
    logic [LINE_W-1:0] line_q;
    logic              valid_q;
    logic              in_pkt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q    <= '0;
            line_q   <= '0;
            valid_q  <= 1'b0;
            in_pkt_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (flit_valid) begin
                case (flit_kind_e'(flit_kind))
                    FK_HEAD: begin
                        hdr_q    <= hdr_unpack(flit_data[HDR_W-1:0]);
                        line_q   <= '0;
                        in_pkt_q <= 1'b1;
                    end
                    FK_SOLO: begin
                        hdr_q    <= hdr_unpack(flit_data[HDR_W-1:0]);
                        line_q   <= '0;
                        valid_q  <= 1'b1;
                        in_pkt_q <= 1'b0;
                    end
                    FK_BODY: line_q <= {flit_data, line_q[LINE_W-1:FLIT_W]};
                    FK_TAIL: begin
                        line_q   <= {flit_data, line_q[LINE_W-1:FLIT_W]};
                        valid_q  <= 1'b1;
                        in_pkt_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign msg_valid = valid_q;
    assign msg_hdr   = hdr_q;
    assign msg_line  = line_q;

    // R9: completion only follows a closing flit
    p_done_after_tail_r9: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(flit_valid && (flit_kind == FK_TAIL || flit_kind == FK_SOLO)));

    // R10: data flits belong to an opened packet
    p_body_in_packet_r10: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && (flit_kind == FK_BODY || flit_kind == FK_TAIL)) |-> in_pkt_q);
endmodule

// File: rtl/coh_msg_ni.sv
module coh_msg_ni
    import coh_ni_pkg::*;
#(
    parameter bit SHARE_RSP_UNBLK = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tx_msg_valid,
    output logic                 tx_msg_ready,
    input  logic [CLS_W-1:0]     tx_msg_class,
    input  logic                 tx_msg_has_line,
    input  logic [MTYPE_W-1:0]   tx_msg_type,
    input  logic [NODE_W-1:0]    tx_msg_dest,
    input  logic [ADDR_W-1:0]    tx_msg_addr,
    input  logic [LINE_W-1:0]    tx_msg_line,
    input  logic [NUM_VNETS-1:0] tx_vnet_stall,
    output logic                 tx_flit_valid,
    output logic [1:0]           tx_flit_kind,
    output logic [VNET_W-1:0]    tx_flit_vnet,
    output logic [FLIT_W-1:0]    tx_flit_data,
    input  logic                 rx_flit_valid,
    input  logic [1:0]           rx_flit_kind,
    input  logic [FLIT_W-1:0]    rx_flit_data,
    output logic                 rx_msg_valid,
    output logic [CLS_W-1:0]     rx_msg_class,
    output logic                 rx_msg_has_line,
    output logic [MTYPE_W-1:0]   rx_msg_type,
    output logic [NODE_W-1:0]    rx_msg_dest,
    output logic [ADDR_W-1:0]    rx_msg_addr,
    output logic [LINE_W-1:0]    rx_msg_line
);
    hdr_t       tx_hdr;
    hdr_t       rx_hdr;
    flit_kind_e tx_kind;

    always_comb begin
        tx_hdr.cls      = msg_class_e'(tx_msg_class);
        tx_hdr.has_line = tx_msg_has_line;
        tx_hdr.mtype    = tx_msg_type;
        tx_hdr.dest     = tx_msg_dest;
        tx_hdr.addr     = tx_msg_addr;
    end

    coh_ni_tx #(.SHARE_RSP_UNBLK(SHARE_RSP_UNBLK)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (tx_msg_valid),
        .msg_ready  (tx_msg_ready),
        .msg_hdr    (tx_hdr),
        .msg_line   (tx_msg_line),
        .stall      (tx_vnet_stall),
        .flit_valid (tx_flit_valid),
        .flit_kind  (tx_kind),
        .flit_vnet  (tx_flit_vnet),
        .flit_data  (tx_flit_data)
    );
    assign tx_flit_kind = tx_kind;

    coh_ni_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .flit_valid (rx_flit_valid),
        .flit_kind  (rx_flit_kind),
        .flit_data  (rx_flit_data),
        .msg_valid  (rx_msg_valid),
        .msg_hdr    (rx_hdr),
        .msg_line   (rx_msg_line)
    );

    assign rx_msg_class    = rx_hdr.cls;
    assign rx_msg_has_line = rx_hdr.has_line;
    assign rx_msg_type     = rx_hdr.mtype;
    assign rx_msg_dest     = rx_hdr.dest;
    assign rx_msg_addr     = rx_hdr.addr;

    // R7: never offer a flit into a stalled network
    p_respect_stall_r7: assert property (@(posedge clk) disable iff (rst)
        tx_flit_valid |-> !tx_vnet_stall[tx_flit_vnet]);
endmodule

// File: tb/coh_msg_ni_bench.sv
module coh_msg_ni_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         tx_msg_valid = 1'b0;
    logic         tx_msg_ready, tx_msg_ready_s;
    logic [2:0]   tx_msg_class = '0;
    logic         tx_msg_has_line = 1'b0;
    logic [7:0]   tx_msg_type = '0;
    logic [7:0]   tx_msg_dest = '0;
    logic [47:0]  tx_msg_addr = '0;
    logic [511:0] tx_msg_line = '0;
    logic [5:0]   tx_vnet_stall = '0;
    logic         tx_flit_valid, tx_flit_valid_s;
    logic [1:0]   tx_flit_kind, tx_flit_kind_s;
    logic [2:0]   tx_flit_vnet, tx_flit_vnet_s;
    logic [127:0] tx_flit_data, tx_flit_data_s;
    logic         rx_msg_valid, rx_msg_valid_s;
    logic [2:0]   rx_msg_class, rx_msg_class_s;
    logic         rx_msg_has_line, rx_msg_has_line_s;
    logic [7:0]   rx_msg_type, rx_msg_type_s;
    logic [7:0]   rx_msg_dest, rx_msg_dest_s;
    logic [47:0]  rx_msg_addr, rx_msg_addr_s;
    logic [511:0] rx_msg_line, rx_msg_line_s;

    coh_msg_ni #(.SHARE_RSP_UNBLK(1'b0)) u_coh_msg_ni (
        .clk(clk), .rst(rst),
        .tx_msg_valid(tx_msg_valid), .tx_msg_ready(tx_msg_ready),
        .tx_msg_class(tx_msg_class), .tx_msg_has_line(tx_msg_has_line),
        .tx_msg_type(tx_msg_type), .tx_msg_dest(tx_msg_dest),
        .tx_msg_addr(tx_msg_addr), .tx_msg_line(tx_msg_line),
        .tx_vnet_stall(tx_vnet_stall),
        .tx_flit_valid(tx_flit_valid), .tx_flit_kind(tx_flit_kind),
        .tx_flit_vnet(tx_flit_vnet), .tx_flit_data(tx_flit_data),
        .rx_flit_valid(tx_flit_valid), .rx_flit_kind(tx_flit_kind),
        .rx_flit_data(tx_flit_data),
        .rx_msg_valid(rx_msg_valid), .rx_msg_class(rx_msg_class),
        .rx_msg_has_line(rx_msg_has_line), .rx_msg_type(rx_msg_type),
        .rx_msg_dest(rx_msg_dest), .rx_msg_addr(rx_msg_addr),
        .rx_msg_line(rx_msg_line)
    );

    coh_msg_ni #(.SHARE_RSP_UNBLK(1'b1)) u_coh_msg_ni_shr (
        .clk(clk), .rst(rst),
        .tx_msg_valid(tx_msg_valid), .tx_msg_ready(tx_msg_ready_s),
        .tx_msg_class(tx_msg_class), .tx_msg_has_line(tx_msg_has_line),
        .tx_msg_type(tx_msg_type), .tx_msg_dest(tx_msg_dest),
        .tx_msg_addr(tx_msg_addr), .tx_msg_line(tx_msg_line),
        .tx_vnet_stall(tx_vnet_stall),
        .tx_flit_valid(tx_flit_valid_s), .tx_flit_kind(tx_flit_kind_s),
        .tx_flit_vnet(tx_flit_vnet_s), .tx_flit_data(tx_flit_data_s),
        .rx_flit_valid(tx_flit_valid_s), .rx_flit_kind(tx_flit_kind_s),
        .rx_flit_data(tx_flit_data_s),
        .rx_msg_valid(rx_msg_valid_s), .rx_msg_class(rx_msg_class_s),
        .rx_msg_has_line(rx_msg_has_line_s), .rx_msg_type(rx_msg_type_s),
        .rx_msg_dest(rx_msg_dest_s), .rx_msg_addr(rx_msg_addr_s),
        .rx_msg_line(rx_msg_line_s)
    );

    typedef struct {
        logic [1:0]   kind;
        logic [2:0]   vnet;
        logic [2:0]   svnet;
        logic [127:0] data;
        string        req;
    } exp_flit_t;

    typedef struct {
        logic [2:0]   cls;
        logic         has_line;
        logic [7:0]   mtype;
        logic [7:0]   dest;
        logic [47:0]  addr;
        logic [511:0] line;
    } exp_msg_t;

    exp_flit_t flit_q[$];
    exp_msg_t  msg_q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_end_cyc = -10;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Driver: computes expected flits and messages, then performs the handshake.
    task automatic send_msg(input logic [2:0] cls, input logic hl, input logic [7:0] mt,
                            input logic [7:0] dst, input logic [47:0] ad,
                            input logic [511:0] ln);
        logic         lng;
        logic [127:0] hdr;
        exp_flit_t    f;
        exp_msg_t     m;
        lng = hl && (cls == 3'd4 || cls == 3'd1);
        hdr = {60'd0, ad, dst, mt, lng, cls};          // R4 layout
        f.vnet  = cls;                                   // R5
        f.svnet = (cls == 3'd5) ? 3'd4 : cls;            // R6
        f.kind  = lng ? 2'd1 : 2'd3;
        f.data  = hdr;
        f.req   = lng ? "R3" : "R2";
        flit_q.push_back(f);
        if (lng) begin
            for (int k = 0; k < 4; k++) begin
                f.kind = (k == 3) ? 2'd2 : 2'd0;
                f.data = ln[k*128 +: 128];
                f.req  = "R3";
                flit_q.push_back(f);
            end
        end
        m.cls = cls; m.has_line = lng; m.mtype = mt; m.dest = dst; m.addr = ad;
        m.line = lng ? ln : 512'd0;                       // R10
        msg_q.push_back(m);

        @(negedge clk);
        tx_msg_class = cls; tx_msg_has_line = hl; tx_msg_type = mt;
        tx_msg_dest = dst; tx_msg_addr = ad; tx_msg_line = ln;
        tx_msg_valid = 1'b1;
        while (!tx_msg_ready) @(negedge clk);
        @(negedge clk);
        tx_msg_valid = 1'b0;
        #3;
        chk(tx_msg_ready == 1'b0, "R8", "ready after accept", 512'(tx_msg_ready), 512'd0);
    endtask

    function automatic logic [511:0] mkline(input int seed);
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = 32'(seed * 32'h01000193 + i * 32'h9E3779B9);
        return v;
    endfunction

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst) begin
                if (tx_flit_valid) begin
                    exp_flit_t e;
                    chk(!tx_vnet_stall[tx_flit_vnet], "R7", "flit under stall",
                        512'(tx_vnet_stall), 512'(tx_flit_vnet));
                    if (flit_q.size() == 0) begin
                        chk(1'b0, "R8", "unexpected flit", 512'(tx_flit_data), 512'd0);
                    end else begin
                        e = flit_q.pop_front();
                        chk(tx_flit_kind == e.kind, e.req, "flit kind", 512'(tx_flit_kind), 512'(e.kind));
                        chk(tx_flit_data == e.data, (e.kind == 2'd1 || e.kind == 2'd3) ? "R4" : "R3",
                            "flit data", 512'(tx_flit_data), 512'(e.data));
                        chk(tx_flit_vnet == e.vnet, "R5", "vnet", 512'(tx_flit_vnet), 512'(e.vnet));
                        chk(tx_flit_valid_s && tx_flit_vnet_s == e.svnet, "R6", "shared vnet",
                            512'(tx_flit_vnet_s), 512'(e.svnet));
                        if (e.kind == 2'd2 || e.kind == 2'd3) last_end_cyc = cyc;
                    end
                end
                if (rx_msg_valid) begin
                    exp_msg_t m;
                    chk(cyc == last_end_cyc + 1, "R9", "completion cycle",
                        512'(cyc), 512'(last_end_cyc + 1));
                    if (msg_q.size() == 0) begin
                        chk(1'b0, "R9", "unexpected message", 512'(rx_msg_class), 512'd0);
                    end else begin
                        m = msg_q.pop_front();
                        chk(rx_msg_line == m.line, "R10", "line", rx_msg_line, m.line);
                        chk({rx_msg_class, rx_msg_has_line, rx_msg_type, rx_msg_dest, rx_msg_addr} ==
                            {m.cls, m.has_line, m.mtype, m.dest, m.addr}, "R11", "header fields",
                            512'({rx_msg_class, rx_msg_has_line, rx_msg_type, rx_msg_dest, rx_msg_addr}),
                            512'({m.cls, m.has_line, m.mtype, m.dest, m.addr}));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (flit_q.size() == 0 && msg_q.size() == 0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #3;
        chk(tx_msg_ready == 1'b1, "R1", "ready after reset", 512'(tx_msg_ready), 512'd1);
        chk(tx_flit_valid == 1'b0, "R1", "flit valid after reset", 512'(tx_flit_valid), 512'd0);
        chk(rx_msg_valid == 1'b0, "R1", "msg valid after reset", 512'(rx_msg_valid), 512'd0);

        // R2 / R5: control classes
        send_msg(3'd2, 1'b0, 8'h11, 8'h05, 48'h0000_1234_5640, mkline(1));
        send_msg(3'd3, 1'b0, 8'h22, 8'h1A, 48'hABCD_0000_0080, mkline(2));
        send_msg(3'd5, 1'b0, 8'h33, 8'h3F, 48'h0F0F_F0F0_00C0, mkline(3)); // R6 too
        send_msg(3'd4, 1'b0, 8'h44, 8'h07, 48'h0000_0000_0100, mkline(4));
        // R2: line flag ignored on a non-response class
        send_msg(3'd0, 1'b1, 8'h55, 8'h02, 48'h1111_2222_3340, mkline(5));
        // R3: data responses
        send_msg(3'd4, 1'b1, 8'h66, 8'h09, 48'hFFFF_FFFF_FFC0, mkline(6));
        send_msg(3'd1, 1'b1, 8'h77, 8'h0C, 48'h8000_0000_0040, mkline(7));
        drain();

        // R7: stall before head leaves
        tx_vnet_stall = 6'b010000;
        send_msg(3'd4, 1'b1, 8'h88, 8'h10, 48'h0000_DEAD_BE00, mkline(8));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #3;
            chk(tx_flit_valid == 1'b0, "R7", "held by stall", 512'(tx_flit_valid), 512'd0);
            chk(tx_msg_ready == 1'b0, "R8", "ready while held", 512'(tx_msg_ready), 512'd0);
        end
        @(negedge clk);
        tx_vnet_stall = '0;
        drain();

        // R7: stall on another network does not hold this packet
        tx_vnet_stall = 6'b000100;
        send_msg(3'd3, 1'b0, 8'h99, 8'h21, 48'h0000_0101_0100, mkline(9));
        drain();
        chk(flit_q.size() == 0, "R7", "unrelated stall", 512'(flit_q.size()), 512'd0);
        tx_vnet_stall = '0;

        // R7 / R8: stall in the middle of a five-flit packet
        fork
            send_msg(3'd1, 1'b1, 8'hAA, 8'h30, 48'h0000_7777_0040, mkline(10));
            begin
                repeat (3) @(negedge clk);
                tx_vnet_stall = 6'b000010;
                repeat (4) @(negedge clk);
                tx_vnet_stall = '0;
            end
        join
        drain();

        // Back-to-back single-flit messages after a long one
        send_msg(3'd4, 1'b1, 8'hBB, 8'h3E, 48'h0000_0000_0FC0, mkline(11));
        send_msg(3'd5, 1'b0, 8'hCC, 8'h01, 48'h0000_0000_1000, mkline(12));
        send_msg(3'd2, 1'b1, 8'hDD, 8'h02, 48'h0000_0000_1040, mkline(13));
        drain();

        chk(flit_q.size() == 0 && msg_q.size() == 0, "R9", "all messages delivered",
            512'(flit_q.size() + msg_q.size()), 512'd0);
        finish_run();
    end
endmodule